// File: doc/BRIEF.md
# Store Ordering Buffer with Persistence Fencing

This block sits between a processor core and a cache-line array. The core hands it three kinds of operation, in program order: stores, cache-line write-back requests, and store fences. A store's address and data may arrive later, in either order, through separate fill ports. Each entry is marked retired, oldest first, through a retire strobe. Stores are written into the line array one at a time, oldest first, and only once they are retired and complete.

A write-back request takes a snapshot of its whole line and sends it to a persistence port. Acknowledgments come back by ID and may arrive in any order. The only thing a write-back must wait for is every older store to the same line. An older store whose address is still unknown counts as a possible match. Write-backs are not ordered against each other, nor against younger stores to other lines.

A fence entry holds back every younger operation until two things are true: all older stores have been written, and all older write-backs have been acknowledged as persistent. Every store write and every fence release produces an event record, so that the ordering can be observed from outside.

Top module: `sbf_top`

## Requirements
- R1: The buffer holds DEPTH (8) entries. `alloc_ready` is low while all of them are in use. `alloc_idx` gives the slot that an accepted operation takes. Slots are released oldest first, once their work is done. `alloc_kind` encoding: 0 = store, 1 = write-back, 2 = fence.
- R2: A store is written to the line array only after it has been retired and has both its address and its data. Its write is announced in that same cycle on `ev_valid`, with `ev_kind` = 0 and `ev_id` = the operation's sequence number. Operations are numbered from 0 after reset, one per accepted allocation of any kind.
- R3: Stores are written strictly in allocation order, whatever order their fills arrive in.
- R4: A write-back is not sent while any older store to the same 64-byte line is unwritten or still has no address. Lines match on address bits 15..6. The line data it sends (`pq_data`, word w in bits 32w+31..32w, word index = address bits 5..2) includes every older store to that line.
- R5: Write-backs are not ordered among themselves. A younger write-back to another line is sent while an older one is still blocked.
- R6: A younger store to a different line is written while an older write-back is still unacknowledged.
- R7: A fence entry is released only when every older store has been written and every older write-back has been acknowledged. Its release is announced with `ev_kind` = 1. No younger store is written, and no younger write-back is sent, before that release.
- R8: A request on the persistence port stays valid, with the same `pq_id`, until `pq_ready` is seen high. `pq_id` is the write-back's sequence number.
- R9: Acknowledgments (`ack_id` = sequence number) are accepted in any order. Each one completes its write-back and lets its slot be released.
- R10: After reset, `alloc_ready` is high and `pq_valid` and `ev_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Offer a new operation |
| alloc_kind | input | 2 | 0 store, 1 write-back, 2 fence |
| alloc_ready | output | 1 | A slot is free |
| alloc_idx | output | 3 | Slot the offered operation takes |
| fa_valid | input | 1 | Address fill strobe |
| fa_idx | input | 3 | Slot being given an address |
| fa_addr | input | 16 | Byte address |
| fd_valid | input | 1 | Data fill strobe |
| fd_idx | input | 3 | Slot being given data |
| fd_data | input | 32 | Store word |
| retire_valid | input | 1 | Retire the oldest unretired entry |
| pq_valid | output | 1 | Write-back request valid |
| pq_ready | input | 1 | Persistence side takes the request |
| pq_id | output | 8 | Sequence number of the request |
| pq_addr | output | 16 | Address given with the write-back |
| pq_data | output | 512 | Snapshot of the whole line |
| ack_valid | input | 1 | Persistence acknowledgment |
| ack_id | input | 8 | Sequence number being acknowledged |
| ev_valid | output | 1 | Event record valid |
| ev_kind | output | 1 | 0 store written, 1 fence released |
| ev_id | output | 8 | Sequence number of the event's operation |
| ev_cycle | output | 32 | Cycle count since reset |

## Verification
A store's write and its event appear in the cycle right after the clock edge that made it eligible: the edge that registered its last fill, its retirement, or the release of an older fence. A fence release appears one cycle after the edge that registered the last acknowledgment it waited for. A write-back request appears on the port two cycles after the edge on which its blocking store was written, because the request is held in a register. The bench drives inputs on falling edges and samples on falling edges. It waits several cycles beyond these latencies before it checks that something has not happened. A scoreboard holds the expected event sequence, and any event that arrives when nothing is expected is a failure.

// File: rtl/sbf_pkg.sv
// Shared types for the store ordering buffer.
// Assumes: kind codes are fixed by the allocation port encoding.
package sbf_pkg;
    typedef enum logic [1:0] {
        K_STORE = 2'd0,
        K_WB    = 2'd1,
        K_FENCE = 2'd2
    } kind_t;

    localparam logic EV_STORE = 1'b0;
    localparam logic EV_FENCE = 1'b1;
endpackage

// File: rtl/sbf_ring.sv
// Head/tail bookkeeping of the entry ring.
// Assumes: DEPTH is a power of two; push is never asserted when full.
module sbf_ring #(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [IW-1:0] head,
    output logic [IW-1:0] tail,
    output logic [IW:0]   count
);
    // Advance pointers and occupancy on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) tail <= tail + 1'b1;
            if (pop)  head <= head + 1'b1;
            count <= count + (IW+1)'(push) - (IW+1)'(pop);
        end
    end
endmodule

// File: rtl/sbf_lines.sv
// Line array: one word write port, one whole-line read port.
// Assumes: read is combinational; a write is visible after the edge.
module sbf_lines #(
    parameter int NLINES = 8,
    parameter int WPL    = 16,
    parameter int DW     = 32,
    localparam int LIW = $clog2(NLINES),
    localparam int WW  = $clog2(WPL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LIW-1:0]    wr_line,
    input  logic [WW-1:0]     wr_word,
    input  logic [DW-1:0]     wr_data,
    input  logic [LIW-1:0]    rd_line,
    output logic [WPL*DW-1:0] rd_data
);
    logic [DW-1:0] mem [NLINES][WPL];

    // Clear on reset, otherwise write one word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < NLINES; l++)
                for (int w = 0; w < WPL; w++)
                    mem[l][w] <= '0;
        end else if (wr_en) begin
            mem[wr_line][wr_word] <= wr_data;
        end
    end

    // Pack the selected line, word 0 in the low bits.
    always_comb begin
        for (int w = 0; w < WPL; w++)
            rd_data[w*DW +: DW] = mem[rd_line][w];
    end
endmodule

// File: rtl/sbf_sched.sv
// Ordering rules: chooses the store to write, the write-back to send and
// the fence to release, from per-slot flags and ages relative to head.
// Assumes: DEPTH is a power of two, so slot minus head gives the age.
module sbf_sched #(
    parameter int DEPTH = 8,
    parameter int TW    = 10,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic [IW-1:0]    head,
    input  logic [DEPTH-1:0] vld,
    input  logic [DEPTH-1:0] is_st,
    input  logic [DEPTH-1:0] is_wb,
    input  logic [DEPTH-1:0] is_fn,
    input  logic [DEPTH-1:0] done,
    input  logic [DEPTH-1:0] retd,
    input  logic [DEPTH-1:0] a_ok,
    input  logic [DEPTH-1:0] d_ok,
    input  logic [DEPTH-1:0] iss,
    input  logic [TW-1:0]    tag [DEPTH],
    output logic [DEPTH-1:0] st_go,
    output logic [DEPTH-1:0] wb_go,
    output logic [DEPTH-1:0] fn_go
);
    logic [IW-1:0]    age [DEPTH];
    logic [DEPTH-1:0] st_p, wb_p, fn_p, wb_el;

    // Age and pending flags per slot.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            age[i]  = IW'(i) - head;
            st_p[i] = vld[i] & is_st[i] & ~done[i];
            wb_p[i] = vld[i] & is_wb[i] & ~done[i];
            fn_p[i] = vld[i] & is_fn[i] & ~done[i];
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic ost, owb, ofn, odep, oel;

        // Summarise what older entries still hold back slot i.
        always_comb begin
            ost = 1'b0; owb = 1'b0; ofn = 1'b0; odep = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                if (age[j] < age[i]) begin
                    ost = ost | st_p[j];
                    owb = owb | wb_p[j];
                    ofn = ofn | fn_p[j];
                    if (st_p[j] && (!a_ok[j] || tag[j] == tag[i]))
                        odep = 1'b1;
                end
            end
        end

        // Eligibility of slot i under each rule.
        always_comb begin
            st_go[i] = st_p[i] & ~ost & ~ofn & retd[i] & a_ok[i] & d_ok[i];
            wb_el[i] = wb_p[i] & ~iss[i] & ~odep & ~ofn & retd[i] & a_ok[i];
            fn_go[i] = fn_p[i] & ~ost & ~owb & ~ofn & retd[i];
        end

        // Oldest eligible write-back wins.
        always_comb begin
            oel = 1'b0;
            for (int j = 0; j < DEPTH; j++)
                if (age[j] < age[i]) oel = oel | wb_el[j];
            wb_go[i] = wb_el[i] & ~oel;
        end
    end
endmodule

// File: rtl/sbf_top.sv
// Store ordering buffer with persistence fencing. Holds stores,
// write-backs and fences in program order; writes stores in order after
// retirement, sends write-back line snapshots, releases fences once older
// work is written and persistent.
// Assumes: acks name an issued, unacknowledged write-back; retire only
// while an unretired entry exists; fills target allocated slots.
module sbf_top #(
    parameter int DEPTH      = 8,
    parameter int AW         = 16,
    parameter int DW         = 32,
    parameter int LINE_BYTES = 64,
    parameter int NLINES     = 8,
    parameter int SEQW       = 8,
    localparam int IW   = $clog2(DEPTH),
    localparam int OFFW = $clog2(LINE_BYTES),
    localparam int BOFF = $clog2(DW/8),
    localparam int WPL  = LINE_BYTES / (DW/8),
    localparam int WW   = $clog2(WPL),
    localparam int LIW  = $clog2(NLINES),
    localparam int LW   = LINE_BYTES * 8,
    localparam int TW   = AW - OFFW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_valid,
    input  logic [1:0]      alloc_kind,
    output logic            alloc_ready,
    output logic [IW-1:0]   alloc_idx,
    input  logic            fa_valid,
    input  logic [IW-1:0]   fa_idx,
    input  logic [AW-1:0]   fa_addr,
    input  logic            fd_valid,
    input  logic [IW-1:0]   fd_idx,
    input  logic [DW-1:0]   fd_data,
    input  logic            retire_valid,
    output logic            pq_valid,
    input  logic            pq_ready,
    output logic [SEQW-1:0] pq_id,
    output logic [AW-1:0]   pq_addr,
    output logic [LW-1:0]   pq_data,
    input  logic            ack_valid,
    input  logic [SEQW-1:0] ack_id,
    output logic            ev_valid,
    output logic            ev_kind,
    output logic [SEQW-1:0] ev_id,
    output logic [31:0]     ev_cycle
);
    import sbf_pkg::*;

    logic [IW-1:0]    head, tail, ret_ptr;
    logic [IW:0]      count;
    logic [DEPTH-1:0] vld, is_st, is_wb, is_fn, done, retd, a_ok, d_ok, iss;
    logic [AW-1:0]    addr_q [DEPTH];
    logic [DW-1:0]    data_q [DEPTH];
    logic [SEQW-1:0]  seq_q  [DEPTH];
    logic [TW-1:0]    tag    [DEPTH];
    logic [SEQW-1:0]  seq_nxt;
    logic [31:0]      cyc;
    logic [DEPTH-1:0] st_go, wb_go, fn_go;
    logic [IW-1:0]    st_idx, wb_idx, fn_idx;
    logic             st_any, wb_any, fn_any;
    logic             alloc_fire, free_fire, ret_fire, req_load;
    logic             req_v;
    logic [SEQW-1:0]  req_id;
    logic [AW-1:0]    req_addr;
    logic [LW-1:0]    req_data, line_rd;
    kind_t            akind;

    assign akind       = kind_t'(alloc_kind);
    assign alloc_ready = (count != (IW+1)'(DEPTH));
    assign alloc_idx   = tail;
    assign alloc_fire  = alloc_valid & alloc_ready;
    assign free_fire   = vld[head] & done[head];
    assign ret_fire    = retire_valid & vld[ret_ptr] & ~retd[ret_ptr];

    sbf_ring #(.DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n), .push(alloc_fire), .pop(free_fire),
        .head(head), .tail(tail), .count(count)
    );

    // Line tags for same-line matching.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) tag[i] = addr_q[i][AW-1:OFFW];
    end

    sbf_sched #(.DEPTH(DEPTH), .TW(TW)) u_sched (
        .head(head), .vld(vld), .is_st(is_st), .is_wb(is_wb), .is_fn(is_fn),
        .done(done), .retd(retd), .a_ok(a_ok), .d_ok(d_ok), .iss(iss),
        .tag(tag), .st_go(st_go), .wb_go(wb_go), .fn_go(fn_go)
    );

    // Turn the one-hot choices into slot indices.
    always_comb begin
        st_idx = '0; wb_idx = '0; fn_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_go[i]) st_idx = IW'(i);
            if (wb_go[i]) wb_idx = IW'(i);
            if (fn_go[i]) fn_idx = IW'(i);
        end
        st_any = |st_go;
        wb_any = |wb_go;
        fn_any = |fn_go;
    end

    sbf_lines #(.NLINES(NLINES), .WPL(WPL), .DW(DW)) u_lines (
        .clk(clk), .rst_n(rst_n),
        .wr_en(st_any),
        .wr_line(addr_q[st_idx][OFFW +: LIW]),
        .wr_word(addr_q[st_idx][BOFF +: WW]),
        .wr_data(data_q[st_idx]),
        .rd_line(addr_q[wb_idx][OFFW +: LIW]),
        .rd_data(line_rd)
    );

    assign req_load = wb_any & (~req_v | pq_ready);

    // Per-slot state: allocation, fills, retirement, completion, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0; is_st <= '0; is_wb <= '0; is_fn <= '0; done <= '0;
            retd <= '0; a_ok <= '0; d_ok <= '0; iss <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                addr_q[i] <= '0; data_q[i] <= '0; seq_q[i] <= '0;
            end
        end else begin
            if (fa_valid) begin
                addr_q[fa_idx] <= fa_addr;
                a_ok[fa_idx]   <= 1'b1;
            end
            if (fd_valid) begin
                data_q[fd_idx] <= fd_data;
                d_ok[fd_idx]   <= 1'b1;
            end
            if (ret_fire) retd[ret_ptr] <= 1'b1;
            if (st_any)   done[st_idx] <= 1'b1;
            if (fn_any)   done[fn_idx] <= 1'b1;
            if (req_load) iss[wb_idx]  <= 1'b1;
            if (ack_valid) begin
                for (int i = 0; i < DEPTH; i++)
                    if (vld[i] && is_wb[i] && iss[i] && seq_q[i] == ack_id)
                        done[i] <= 1'b1;
            end
            if (free_fire) vld[head] <= 1'b0;
            if (alloc_fire) begin
                vld[tail]   <= 1'b1;
                is_st[tail] <= (akind == K_STORE);
                is_wb[tail] <= (akind == K_WB);
                is_fn[tail] <= (akind == K_FENCE);
                done[tail]  <= 1'b0;
                retd[tail]  <= 1'b0;
                a_ok[tail]  <= 1'b0;
                d_ok[tail]  <= 1'b0;
                iss[tail]   <= 1'b0;
                seq_q[tail] <= seq_nxt;
            end
        end
    end

    // Sequence numbering, retire pointer and cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_nxt <= '0;
            ret_ptr <= '0;
            cyc     <= '0;
        end else begin
            if (alloc_fire) seq_nxt <= seq_nxt + 1'b1;
            if (ret_fire)   ret_ptr <= ret_ptr + 1'b1;
            cyc <= cyc + 1'b1;
        end
    end

    // Persistence request register, held until accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_v    <= 1'b0;
            req_id   <= '0;
            req_addr <= '0;
            req_data <= '0;
        end else if (req_load) begin
            req_v    <= 1'b1;
            req_id   <= seq_q[wb_idx];
            req_addr <= addr_q[wb_idx];
            req_data <= line_rd;
        end else if (pq_ready) begin
            req_v <= 1'b0;
        end
    end

    assign pq_valid = req_v;
    assign pq_id    = req_id;
    assign pq_addr  = req_addr;
    assign pq_data  = req_data;

    // Event record for a store write or a fence release.
    always_comb begin
        ev_valid = st_any | fn_any;
        ev_kind  = fn_any ? EV_FENCE : EV_STORE;
        ev_id    = fn_any ? seq_q[fn_idx] : seq_q[st_idx];
        ev_cycle = cyc;
    end
endmodule

// File: rtl/sbf_chk.sv
// Checker for the ordering buffer's externally visible rules.
// Assumes: it sees the top's ports; it keeps its own count of
// outstanding write-backs and the last store sequence number.
module sbf_chk #(
    parameter int DEPTH = 8,
    parameter int SEQW  = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ev_valid,
    input logic            ev_kind,
    input logic [SEQW-1:0] ev_id,
    input logic            pq_valid,
    input logic            pq_ready,
    input logic [SEQW-1:0] pq_id,
    input logic            ack_valid
);
    localparam int CW = $clog2(DEPTH) + 2;
    localparam logic [SEQW-1:0] HALF = SEQW'(1) << (SEQW-1);

    logic [CW-1:0]   outst;
    logic [SEQW-1:0] last_st, sdiff;
    logic            have_st;

    assign sdiff = ev_id - last_st;

    // Track outstanding write-backs and the last written store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst   <= '0;
            last_st <= '0;
            have_st <= 1'b0;
        end else begin
            outst <= outst + CW'(pq_valid & pq_ready) - CW'(ack_valid);
            if (ev_valid && !ev_kind) begin
                last_st <= ev_id;
                have_st <= 1'b1;
            end
        end
    end

    assert_store_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_kind && have_st) |-> (sdiff != '0 && sdiff < HALF));

    assert_fence_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind) |-> (outst == '0));

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pq_valid && !pq_ready) |=> (pq_valid && $stable(pq_id)));

    assert_outst_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        outst <= CW'(DEPTH));
endmodule

bind sbf_top sbf_chk #(.DEPTH(DEPTH), .SEQW(SEQW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_id(ev_id), .pq_valid(pq_valid), .pq_ready(pq_ready),
    .pq_id(pq_id), .ack_valid(ack_valid)
);

// File: tb/sim_sbf_top.sv
// Scoreboard bench for the store ordering buffer.
module sim_sbf_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic         alloc_valid = 0, alloc_ready;
    logic [1:0]   alloc_kind = 0;
    logic [2:0]   alloc_idx;
    logic         fa_valid = 0, fd_valid = 0, retire_valid = 0;
    logic [2:0]   fa_idx = 0, fd_idx = 0;
    logic [15:0]  fa_addr = 0;
    logic [31:0]  fd_data = 0;
    logic         pq_valid, pq_ready = 1;
    logic [7:0]   pq_id;
    logic [15:0]  pq_addr;
    logic [511:0] pq_data;
    logic         ack_valid = 0;
    logic [7:0]   ack_id = 0;
    logic         ev_valid, ev_kind;
    logic [7:0]   ev_id;
    logic [31:0]  ev_cycle;

    sbf_top u0 (.*);

    int checks = 0, bad = 0, evn = 0, sq = 0;
    logic [8:0]   exp_q [$];
    logic [7:0]   rid_q [$];
    logic [511:0] rdat_q [$];

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
        end
    endtask

    // Monitor: compare events with the scoreboard, record requests.
    always @(negedge clk) begin
        if (rst_n && ev_valid) begin
            evn++;
            if (exp_q.size() == 0) chk(0, "R2 unexpected event", {ev_kind, ev_id}, 0);
            else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk({ev_kind, ev_id} == e, "R3/R7 event order", {ev_kind, ev_id}, e);
            end
        end
        if (rst_n && pq_valid && pq_ready) begin
            rid_q.push_back(pq_id);
            rdat_q.push_back(pq_data);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic alloc(input logic [1:0] k, output logic [2:0] idx, output int s);
        int w;
        @(negedge clk);
        alloc_valid = 1; alloc_kind = k; w = 0;
        while (!alloc_ready && w < 50) begin @(negedge clk); w++; end
        chk(alloc_ready, "R1 alloc stalled", 0, 1);
        idx = alloc_idx; s = sq; sq++;
        @(posedge clk); #1 alloc_valid = 0;
    endtask

    task automatic fill_a(input logic [2:0] i, input logic [15:0] a);
        @(negedge clk); fa_valid = 1; fa_idx = i; fa_addr = a;
        @(posedge clk); #1 fa_valid = 0;
    endtask

    task automatic fill_d(input logic [2:0] i, input logic [31:0] d);
        @(negedge clk); fd_valid = 1; fd_idx = i; fd_data = d;
        @(posedge clk); #1 fd_valid = 0;
    endtask

    task automatic retire();
        @(negedge clk); retire_valid = 1;
        @(posedge clk); #1 retire_valid = 0;
    endtask

    task automatic ack(input int id);
        @(negedge clk); ack_valid = 1; ack_id = 8'(id);
        @(posedge clk); #1 ack_valid = 0;
    endtask

    task automatic expect_ev(input bit k, input int id);
        exp_q.push_back({k, 8'(id)});
    endtask

    // Pop one recorded request; check its id and one word of its line.
    task automatic expect_req(input string rq, input int id, input int word, input logic [31:0] d);
        chk(rid_q.size() > 0, rq, rid_q.size(), 1);
        if (rid_q.size() > 0) begin
            logic [7:0] gi;
            logic [511:0] gd;
            gi = rid_q.pop_front();
            gd = rdat_q.pop_front();
            chk(gi == 8'(id), rq, gi, id);
            if (word >= 0) chk(gd[word*32 +: 32] == d, rq, gd[word*32 +: 32], d);
        end
    endtask

    bit finished = 0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [2:0] i0, i1, i2, i3, i4, ix;
        logic [2:0] ia [8];
        int s0, s1, s2, s3, s4, sx, e0;
        int sa [8];

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        chk(alloc_ready == 1, "R10 alloc_ready", alloc_ready, 1);
        chk(pq_valid == 0, "R10 pq_valid", pq_valid, 0);
        chk(ev_valid == 0, "R10 ev_valid", ev_valid, 0);

        // R2 R3: fills out of order, writes only after retire, in order.
        alloc(0, i0, s0); alloc(0, i1, s1);
        fill_a(i1, 16'h0048); fill_d(i1, 32'h22);
        fill_d(i0, 32'h11); fill_a(i0, 16'h0044);
        idle(4);
        chk(evn == 0, "R2 write before retire", evn, 0);
        expect_ev(0, s0); expect_ev(0, s1);
        retire(); retire();
        idle(4);
        chk(exp_q.size() == 0, "R3 stores written", exp_q.size(), 0);

        // R4 R5: same-line write-back waits, other-line one goes first.
        alloc(0, i2, s2); fill_a(i2, 16'h0040);
        alloc(1, i3, s3); fill_a(i3, 16'h0040);
        alloc(1, i4, s4); fill_a(i4, 16'h0080);
        retire(); retire(); retire();
        idle(5);
        chk(rid_q.size() == 1, "R4 blocked write-back sent", rid_q.size(), 1);
        expect_req("R5 younger write-back first", s4, -1, 0);
        expect_ev(0, s2);
        fill_d(i2, 32'hA5A50001);
        idle(5);
        chk(exp_q.size() == 0, "R2 store after data fill", exp_q.size(), 0);
        rid_q.push_front(rid_q.size() > 0 ? rid_q[0] : 8'hFF); rdat_q.push_front(rdat_q.size() > 0 ? rdat_q[0] : '0);
        void'(rid_q.pop_front()); void'(rdat_q.pop_front());
        if (rid_q.size() > 0) begin
            chk(rdat_q[0][32 +: 32] == 32'h11, "R4 snapshot word1", rdat_q[0][32 +: 32], 32'h11);
            chk(rdat_q[0][64 +: 32] == 32'h22, "R4 snapshot word2", rdat_q[0][64 +: 32], 32'h22);
        end
        expect_req("R4 snapshot word0", s3, 0, 32'hA5A50001);
        // R9 acks out of issue order
        ack(s3); ack(s4);

        // R6: younger store to another line passes an unacked write-back.
        alloc(1, ix, sx); fill_a(ix, 16'h0080); retire();
        idle(4);
        expect_req("R6 write-back sent", sx, -1, 0);
        alloc(0, i0, s0); fill_a(i0, 16'h00C0); fill_d(i0, 32'h33);
        e0 = evn;
        expect_ev(0, s0);
        retire();
        idle(3);
        chk(evn == e0 + 1, "R6 store before ack", evn, e0 + 1);
        ack(sx);

        // R7: fence holds a younger store and write-back until the ack.
        alloc(1, ix, sx); fill_a(ix, 16'h0040); retire();
        idle(4);
        expect_req("R7 older write-back sent", sx, -1, 0);
        alloc(2, i1, s1); retire();
        alloc(0, i2, s2); fill_a(i2, 16'h00C4); fill_d(i2, 32'h44); retire();
        alloc(1, i3, s3); fill_a(i3, 16'h0084); retire();
        e0 = evn;
        idle(5);
        chk(evn == e0, "R7 younger store held", evn, e0);
        chk(rid_q.size() == 0, "R7 younger write-back held", rid_q.size(), 0);
        expect_ev(1, s1); expect_ev(0, s2);
        ack(sx);
        idle(5);
        chk(evn == e0 + 2, "R7 release then store", evn, e0 + 2);
        expect_req("R7 write-back after release", s3, -1, 0);
        ack(s3);

        // R8: request held while the port is not ready.
        pq_ready = 0;
        alloc(1, ix, sx); fill_a(ix, 16'h0040); retire();
        idle(2);
        chk(pq_valid == 1 && pq_id == 8'(sx), "R8 request shown", {pq_valid, pq_id}, {1'b1, 8'(sx)});
        idle(3);
        chk(pq_valid == 1 && pq_id == 8'(sx), "R8 request held", {pq_valid, pq_id}, {1'b1, 8'(sx)});
        chk(rid_q.size() == 0, "R8 nothing taken", rid_q.size(), 0);
        pq_ready = 1;
        idle(2);
        expect_req("R8 request taken", sx, -1, 0);
        ack(sx);
        idle(4);

        // R1: fill all slots, stall, then drain with data fills reversed.
        for (int k = 0; k < 8; k++) begin
            alloc(0, ia[k], sa[k]);
            fill_a(ia[k], 16'(16'h0100 + 4*k));
        end
        idle(1);
        chk(alloc_ready == 0, "R1 full stall", alloc_ready, 0);
        for (int k = 0; k < 8; k++) expect_ev(0, sa[k]);
        for (int k = 7; k >= 0; k--) fill_d(ia[k], 32'(32'hC0 + k));
        for (int k = 0; k < 8; k++) retire();
        idle(4);
        chk(exp_q.size() == 0, "R3 full drain in order", exp_q.size(), 0);
        chk(alloc_ready == 1, "R1 slots released", alloc_ready, 1);
        alloc(1, ix, sx); fill_a(ix, 16'h0100); retire();
        idle(4);
        expect_req("R4 line holds word 5", sx, 5, 32'hC5);
        ack(sx);
        idle(4);
        chk(exp_q.size() == 0 && rid_q.size() == 0, "R9 nothing left over", exp_q.size() + rid_q.size(), 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule